// File: doc/BRIEF.md
# Convolutional Interleaver and Deinterleaver Pair

This block scatters a stream of symbols in time and then gathers them back. A forward stage holds NBR parallel branches, each a shift register whose length grows by a fixed step from one branch to the next. The first branch has no storage. A commutator hands each accepted symbol to the next branch in turn. As a symbol enters a branch, the oldest symbol in that branch leaves it and goes to the interleaved output. A reverse stage has the same structure with the branch lengths in mirrored order. It takes the interleaved stream at once and restores the original order.

Both stages step on the same valid strobe, and a single shared commutator drives them, so their branch selection can never drift apart. Every symbol therefore spends the same total number of branch visits in storage, and the restored output is the input stream delayed by a fixed number of symbol slots, LAT = NBR*(NBR-1)*STEP. Both outputs are registered. A flag rises once the restored output carries real data and no longer the zeros left by reset.

Top module: `conv_ilv_pair`

## Requirements
- R1: While reset is high, all delay elements clear and the commutator returns to branch 0. In the cycle after reset, out_vld_o is 0, ilv_sym_o and rcv_sym_o are 0, and rcv_ok_o is 0.
- R2: out_vld_o is high in exactly the cycles that follow a cycle with in_vld_i high.
- R3: The commutator advances by one branch (wrapping from NBR-1 to 0) only on cycles with in_vld_i high. Idle cycles do not move it and do not shift any branch, so gaps in the input do not change which data appears in which output slot.
- R4: Number the accepted symbols s = 0, 1, 2, … from reset. The interleaved output for slot s equals the input of slot s - k*STEP*NBR, where k = s mod NBR. It is 0 when that index is negative.
- R5: Slots with s mod NBR = 0 pass through the forward stage without delay: the interleaved output for such a slot equals that slot's own input.
- R6: The restored output for slot s equals the input of slot s - LAT, with LAT = NBR*(NBR-1)*STEP. It is 0 for s < LAT.
- R7: rcv_ok_o, presented with the outputs of slot s, is 0 for s < LAT and 1 for s >= LAT. Once set, it stays set until reset.
- R8: In a cycle that follows an idle cycle, ilv_sym_o and rcv_sym_o hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Input symbol strobe |
| in_sym_i | input | SYM_W | Input symbol |
| out_vld_o | output | 1 | Outputs updated for the slot accepted in the previous cycle |
| ilv_sym_o | output | SYM_W | Interleaved symbol |
| rcv_sym_o | output | SYM_W | Restored (deinterleaved) symbol |
| rcv_ok_o | output | 1 | Restored output carries real data |

## Verification
The block is driven with three kinds of stream. An unbroken counting stream makes every slot's value unique, so any misplaced branch delay shows up as the wrong index. A random stream with random idle gaps shows that the commutator and branches ignore idle cycles. An alternating pattern with a long idle run tests that outputs hold during the gap. A reset in mid-stream followed by a fresh run confirms that the commutator restarts at branch 0, that the storage comes back as zeros, and that the ready flag rises again exactly LAT slots later.

// File: rtl/cil_pkg.sv
package cil_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } bank_dir_e;

    // Number of stored elements in branch br of a bank
    function automatic int tap_depth(input int br, input int nbr,
                                     input int step, input bank_dir_e dir);
        int pos;
        pos = (dir == DIR_REV) ? (nbr - 1 - br) : br;
        return pos * step;
    endfunction

    // End-to-end latency in symbol slots of the chained pair
    function automatic int span_lat(input int nbr, input int step);
        return nbr * (nbr - 1) * step;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cil_commutator.sv
module cil_commutator #(
    parameter int NBR   = 4,
    localparam int IDX_W = cil_pkg::idx_width(NBR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [IDX_W-1:0] sel_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBR - 1);

    logic [IDX_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (adv_i) begin
            if (sel_q == LAST) sel_q <= '0;
            else               sel_q <= sel_q + 1'b1;
        end
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/cil_branch_bank.sv
module cil_branch_bank #(
    parameter int                 SYM_W = 8,
    parameter int                 NBR   = 4,
    parameter int                 STEP  = 2,
    parameter cil_pkg::bank_dir_e DIR   = cil_pkg::DIR_FWD,
    localparam int                IDX_W = cil_pkg::idx_width(NBR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic [IDX_W-1:0] sel_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [SYM_W-1:0] sym_o
);
    logic [SYM_W-1:0] tail [NBR];

    for (genvar b = 0; b < NBR; b++) begin : g_br
        localparam int DEPTH = cil_pkg::tap_depth(b, NBR, STEP, DIR);
        if (DEPTH == 0) begin : g_pass
            assign tail[b] = sym_i;
        end else begin : g_sr
            logic [SYM_W-1:0] stage [DEPTH];
            logic             hit;
            assign hit = adv_i && (sel_i == IDX_W'(b));
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
                end else if (hit) begin
                    stage[0] <= sym_i;
                    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
                end
            end
            assign tail[b] = stage[DEPTH-1];
        end
    end

    assign sym_o = tail[sel_i];
endmodule

// File: rtl/cil_fill.sv
module cil_fill #(
    parameter int LAT = 24,
    localparam int CW = (LAT > 0) ? $clog2(LAT + 1) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    output logic full_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                                cnt_q <= '0;
        else if (adv_i && cnt_q != CW'(LAT))    cnt_q <= cnt_q + 1'b1;
    end

    assign full_o = (cnt_q == CW'(LAT));
endmodule

// File: rtl/conv_ilv_pair.sv
module conv_ilv_pair #(
    parameter int SYM_W = 8,
    parameter int NBR   = 4,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld_i,
    input  logic [SYM_W-1:0] in_sym_i,
    output logic             out_vld_o,
    output logic [SYM_W-1:0] ilv_sym_o,
    output logic [SYM_W-1:0] rcv_sym_o,
    output logic             rcv_ok_o
);
    localparam int LAT   = cil_pkg::span_lat(NBR, STEP);
    localparam int IDX_W = cil_pkg::idx_width(NBR);

    logic [IDX_W-1:0] sel;
    logic [SYM_W-1:0] ilv_nxt;
    logic [SYM_W-1:0] rcv_nxt;
    logic             full;

    cil_commutator #(.NBR(NBR)) u_comm (
        .clk(clk), .rst(rst), .adv_i(in_vld_i), .sel_o(sel)
    );

    cil_branch_bank #(
        .SYM_W(SYM_W), .NBR(NBR), .STEP(STEP), .DIR(cil_pkg::DIR_FWD)
    ) u_fwd (
        .clk(clk), .rst(rst), .adv_i(in_vld_i), .sel_i(sel),
        .sym_i(in_sym_i), .sym_o(ilv_nxt)
    );

    cil_branch_bank #(
        .SYM_W(SYM_W), .NBR(NBR), .STEP(STEP), .DIR(cil_pkg::DIR_REV)
    ) u_rev (
        .clk(clk), .rst(rst), .adv_i(in_vld_i), .sel_i(sel),
        .sym_i(ilv_nxt), .sym_o(rcv_nxt)
    );

    cil_fill #(.LAT(LAT)) u_fill (
        .clk(clk), .rst(rst), .adv_i(in_vld_i), .full_o(full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_o <= 1'b0;
            ilv_sym_o <= '0;
            rcv_sym_o <= '0;
            rcv_ok_o  <= 1'b0;
        end else begin
            out_vld_o <= in_vld_i;
            if (in_vld_i) begin
                ilv_sym_o <= ilv_nxt;
                rcv_sym_o <= rcv_nxt;
                rcv_ok_o  <= full;
            end
        end
    end
endmodule

// File: rtl/conv_ilv_chk.sv
module conv_ilv_chk #(
    parameter int SYM_W = 8,
    parameter int NBR   = 4,
    localparam int IDX_W = cil_pkg::idx_width(NBR)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld_i,
    input logic             out_vld_o,
    input logic [SYM_W-1:0] ilv_sym_o,
    input logic [SYM_W-1:0] rcv_sym_o,
    input logic             rcv_ok_o,
    input logic [IDX_W-1:0] sel
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_vld_o && ilv_sym_o == '0 && rcv_sym_o == '0 && !rcv_ok_o && sel == '0)); // R1

    AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_vld_i |=> out_vld_o); // R2

    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> !out_vld_o); // R2

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> $stable(sel)); // R3

    AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && sel != IDX_W'(NBR - 1)) |=> (sel == $past(sel) + 1'b1)); // R3

    AST_SEL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && sel == IDX_W'(NBR - 1)) |=> (sel == '0)); // R3

    AST_OK_STICKY: assert property (@(posedge clk) disable iff (rst)
        rcv_ok_o |=> rcv_ok_o); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> ($stable(ilv_sym_o) && $stable(rcv_sym_o))); // R8
endmodule

bind conv_ilv_pair conv_ilv_chk #(.SYM_W(SYM_W), .NBR(NBR)) u_chk (
    .clk(clk), .rst(rst), .in_vld_i(in_vld_i), .out_vld_o(out_vld_o),
    .ilv_sym_o(ilv_sym_o), .rcv_sym_o(rcv_sym_o), .rcv_ok_o(rcv_ok_o),
    .sel(sel)
);

// File: tb/tb_conv_ilv_pair.sv
module tb_conv_ilv_pair;
    localparam int SYM_W = 8;
    localparam int NBR   = 4;
    localparam int STEP  = 2;
    localparam int LAT   = NBR * (NBR - 1) * STEP;
    localparam int HMAX  = 1024;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_vld_i;
    logic [SYM_W-1:0] in_sym_i;
    logic             out_vld_o;
    logic [SYM_W-1:0] ilv_sym_o;
    logic [SYM_W-1:0] rcv_sym_o;
    logic             rcv_ok_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [SYM_W-1:0] hist [HMAX];
    int  slot;        // number of accepted symbols since reset
    bit  pend;        // previous cycle had a valid
    int  pend_s;
    logic [SYM_W-1:0] last_ilv, last_rcv;

    always #4 clk = ~clk;

    conv_ilv_pair #(.SYM_W(SYM_W), .NBR(NBR), .STEP(STEP)) dut (
        .clk(clk), .rst(rst), .in_vld_i(in_vld_i), .in_sym_i(in_sym_i),
        .out_vld_o(out_vld_o), .ilv_sym_o(ilv_sym_o), .rcv_sym_o(rcv_sym_o),
        .rcv_ok_o(rcv_ok_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s slot=%0d actual=%0h expected=%0h", req, pend_s, act, exp);
        end
    endtask

    function automatic logic [SYM_W-1:0] exp_ilv(input int s);
        int d;
        d = (s % NBR) * STEP * NBR;
        return (s >= d) ? hist[s-d] : '0;
    endfunction

    function automatic logic [SYM_W-1:0] exp_rcv(input int s);
        return (s >= LAT) ? hist[s-LAT] : '0;
    endfunction

    // Check outputs produced by the previous cycle (we are at a negedge)
    task automatic check_prev();
        if (pend) begin
            chk("R2 out_vld", out_vld_o, 1);
            if (pend_s % NBR == 0) chk("R5 pass", ilv_sym_o, hist[pend_s]);
            chk("R4 ilv", ilv_sym_o, exp_ilv(pend_s));
            chk("R6 rcv", rcv_sym_o, exp_rcv(pend_s));
            chk("R7 ok", rcv_ok_o, (pend_s >= LAT) ? 1 : 0);
        end else begin
            chk("R2 idle", out_vld_o, 0);
            chk("R8 hold ilv", ilv_sym_o, last_ilv);
            chk("R8 hold rcv", rcv_sym_o, last_rcv);
        end
        last_ilv = ilv_sym_o;
        last_rcv = rcv_sym_o;
    endtask

    task automatic step(input bit v, input logic [SYM_W-1:0] sym);
        @(negedge clk);
        check_prev();
        in_vld_i = v;
        in_sym_i = v ? sym : 8'hxx ^ 8'h00;
        if (!v) in_sym_i = sym; // idle data must be ignored (R3)
        pend = v;
        if (v) begin
            pend_s = slot;
            hist[slot] = sym;
            slot++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_vld_i = 1'b0; in_sym_i = 8'h5A;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        pend_s = -1;
        chk("R1 vld", out_vld_o, 0);
        chk("R1 ilv", ilv_sym_o, 0);
        chk("R1 rcv", rcv_sym_o, 0);
        chk("R1 ok", rcv_ok_o, 0);
        slot = 0; pend = 0;
        last_ilv = ilv_sym_o; last_rcv = rcv_sym_o;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_vld_i = 1'b0; in_sym_i = '0;
        pend = 0; pend_s = -1; slot = 0;
        do_reset();

        // Counting stream, back to back: unique values expose wrong delays (R4, R5, R6, R7)
        for (int i = 0; i < 120; i++) step(1'b1, SYM_W'(i + 1));

        // Random stream with random idle gaps (R3, R8)
        for (int i = 0; i < 200; i++) begin
            if ($urandom % 3 == 0) step(1'b0, SYM_W'($urandom));
            else                   step(1'b1, SYM_W'($urandom));
        end

        // Alternating pattern with a long idle run in the middle (R8)
        for (int i = 0; i < 40; i++) step(1'b1, (i % 2) ? 8'hAA : 8'h55);
        for (int i = 0; i < 12; i++) step(1'b0, 8'hFF);
        for (int i = 0; i < 40; i++) step(1'b1, (i % 2) ? 8'h55 : 8'hAA);

        // Reset mid-stream, then restart: commutator at branch 0, storage zero (R1, R7)
        step(1'b0, 8'h00);
        do_reset();
        for (int i = 0; i < 60; i++) step(1'b1, SYM_W'(8'hC0 + i));
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule